// File: doc/BRIEF.md
# Sensor Register Map with Auto-Advancing Pointer

This block is the register file of a three-axis sensor slave. It sits behind a byte-level serial-bus front end that has already matched the device address. That front end gives three one-cycle strobes: a transaction start, a byte written by the master, and a request for a byte to send back. The first byte written after a start is taken as the register pointer. Every later written byte, and every read, is a data access at the pointer.

After each data access the pointer moves on by a non-linear rule. When it stands on the status location it jumps back to the first axis byte. From the last identification location, or from any higher value, it goes to zero. Otherwise it adds one. A master can therefore read the six axis bytes and the status byte over and over with a single burst. The configuration and mode registers are writable and appear as outputs. The axis, status and identification bytes are read-only. The axis and status bytes are loaded from a sample-update port, and a write into the mode register raises a one-cycle pulse for the measurement control logic.

Top module: `sensor_regmap`

## Requirements
- R1: During synchronous active-low reset, and right after it, cfg_a is 0x10, cfg_b is 0x20, mode is 0x01, mode_pulse is 0, rd_byte is 0x00, all axis and status bytes are 0 and the pointer is 0. A read with no prior start therefore returns cfg_a.
- R2: The first byte written after a bus_start loads the pointer and changes no register. A transaction that carries only this pointer byte just repositions the pointer.
- R3: Each data read and each data write moves the pointer: from 9 to 3; otherwise from 12 or above to 0; otherwise up by one. Pointer loads do not advance it.
- R4: A read returns, in rd_byte on the cycle after rd_req and held until the next read: address 0 config A, 1 config B, 2 mode, 3 X high, 4 X low, 5 Z high, 6 Z low, 7 Y high, 8 Y low, 9 status, 10/11/12 the identification constants 0x48, 0x34 and 0x33.
- R5: A read at an address above 12 returns 0x00.
- R6: A write keeps only the defined bits: bits 4:0 of config A, bits 7:5 of config B and bits 1:0 of mode. All undefined bits read as 0, and config A bits 7:5 are always 0.
- R7: Writes to addresses 3 and above change no stored byte, but they still advance the pointer.
- R8: A one-cycle smp_load captures smp_x, smp_z, smp_y and smp_status together. The new values are readable from the next cycle, and the stored bytes do not change without smp_load.
- R9: mode_pulse is high for exactly one cycle, in the cycle after each data write to address 2, whatever the value written.
- R10: cfg_a, cfg_b and mode show the stored register contents, updated in the cycle after a write, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Start of an addressed transaction; arms pointer load |
| wr_valid | input | 1 | Strobe: a byte was written by the master |
| wr_byte | input | 8 | Written byte |
| rd_req | input | 1 | Strobe: the master wants the next byte |
| rd_byte | output | 8 | Byte read at the pointer, registered |
| smp_load | input | 1 | Strobe: capture a new sample |
| smp_x | input | 16 | X axis sample |
| smp_y | input | 16 | Y axis sample |
| smp_z | input | 16 | Z axis sample |
| smp_status | input | 8 | Status byte captured with the sample |
| cfg_a | output | 8 | Configuration A contents (rate and bias codes) |
| cfg_b | output | 8 | Configuration B contents |
| mode | output | 8 | Mode register contents |
| mode_pulse | output | 1 | One-cycle pulse after a mode write |

## Verification
The bench places the pointer at every address from 0 to 20 and reads a long burst from each. A pointer that counts linearly past 9, that wraps only at exactly 12, or that never returns from high addresses shows up as a byte out of sequence. Every address from 0 to 15 is written with several bit patterns and then read back. A design that stores undefined bits, lets a write reach a read-only byte, or stops advancing on an ignored write returns the wrong byte. The bench also sends transactions that carry only a pointer byte, which must not write anything. It checks that mode_pulse fires only after a mode write and lasts one cycle.

// File: rtl/sensor_regmap_pkg.sv
// Shared constants, types and the pointer advance rule for the sensor
// register map. Assumes byte-wide registers and a fixed location layout.
package sensor_regmap_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned NUM_RW   = 3;
    localparam int unsigned NUM_AXIS = 3;
    localparam int unsigned NUM_ID   = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t A_CFG_A     = 8'd0;
    localparam byte_t A_MODE      = 8'd2;
    localparam byte_t A_DATA_BASE = byte_t'(NUM_RW);
    localparam byte_t A_STATUS    = byte_t'(NUM_RW + 2 * NUM_AXIS);
    localparam byte_t A_ID_BASE   = byte_t'(NUM_RW + 2 * NUM_AXIS + 1);
    localparam byte_t A_LAST      = byte_t'(NUM_RW + 2 * NUM_AXIS + NUM_ID);

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_PTR  = 2'd1,
        ACC_WR   = 2'd2,
        ACC_RD   = 2'd3
    } acc_t;

    // Next pointer after a data access: status->first axis, last/above->0.
    function automatic byte_t ptr_advance(input byte_t p);
        if (p == A_STATUS)
            return A_DATA_BASE;
        else if (p >= A_LAST)
            return '0;
        else
            return byte_t'(p + 8'd1);
    endfunction

endpackage

// File: rtl/sensor_ptr_ctrl.sv
// Classifies each bus event as pointer load, data write or data read, and
// keeps the register pointer. Assumes the strobes never coincide; if they
// do, bus_start wins and a write wins over a read.
module sensor_ptr_ctrl
    import sensor_regmap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bus_start,
    input  logic  wr_valid,
    input  byte_t wr_byte,
    input  logic  rd_req,
    output byte_t ptr,
    output acc_t  acc
);

    logic ptr_pending;

    // Decode the current event into an access kind.
    always_comb begin
        if (bus_start)
            acc = ACC_NONE;
        else if (wr_valid)
            acc = ptr_pending ? ACC_PTR : ACC_WR;
        else if (rd_req)
            acc = ACC_RD;
        else
            acc = ACC_NONE;
    end

    // Track whether the next written byte is a pointer byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_pending <= 1'b0;
        else if (bus_start)
            ptr_pending <= 1'b1;
        else if (acc != ACC_NONE)
            ptr_pending <= 1'b0;
    end

    // Load the pointer or advance it after a data access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (acc == ACC_PTR)
            ptr <= wr_byte;
        else if (acc == ACC_WR || acc == ACC_RD)
            ptr <= ptr_advance(ptr);
    end

    // R3
    ptr_rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc == ACC_WR || acc == ACC_RD) && ptr == A_STATUS) |=> ptr == A_DATA_BASE);
    // R3
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc == ACC_WR || acc == ACC_RD) && ptr >= A_LAST) |=> ptr == 8'd0);
    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_PTR) |=> ptr == $past(wr_byte));
    // R3
    ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_NONE) |=> $stable(ptr));

endmodule

// File: rtl/sensor_cfg_regs.sv
// Writable configuration and mode registers with per-register masks of
// defined bits, plus the mode-write pulse. Assumes register i sits at
// address i and that the mode register sits at address 2.
module sensor_cfg_regs
    import sensor_regmap_pkg::*;
#(
    parameter logic [NUM_RW*BYTE_W-1:0] RST_VALS = 24'h01_20_10,
    parameter logic [NUM_RW*BYTE_W-1:0] MASKS    = 24'h03_E0_1F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  byte_t                    wr_addr,
    input  byte_t                    wr_data,
    output logic [NUM_RW*BYTE_W-1:0] rw_flat,
    output logic                     mode_pulse
);

    // Store masked write data into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_flat <= RST_VALS & MASKS;
        end else begin
            for (int i = 0; i < NUM_RW; i++) begin
                if (wr_en && wr_addr == byte_t'(i))
                    rw_flat[i*BYTE_W +: BYTE_W] <= wr_data & MASKS[i*BYTE_W +: BYTE_W];
            end
        end
    end

    // Raise a one-cycle pulse after any write into the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_pulse <= 1'b0;
        else
            mode_pulse <= wr_en && (wr_addr == A_MODE);
    end

    // R6
    undef_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_flat & ~MASKS) == '0);
    // R9
    mode_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pulse |=> !mode_pulse);
    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rw_flat));

endmodule

// File: rtl/sensor_data_regs.sv
// Read-only sample storage: one register per axis and a status byte, all
// loaded together by a single-cycle strobe. Axis order is storage order.
module sensor_data_regs
    import sensor_regmap_pkg::*;
#(
    parameter int unsigned AXIS_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_load,
    input  logic [NUM_AXIS*AXIS_W-1:0] smp_axes,
    input  byte_t                      smp_status,
    output logic [NUM_AXIS*AXIS_W-1:0] axes_q,
    output byte_t                      status_q
);

    for (genvar g = 0; g < NUM_AXIS; g++) begin : g_axis
        logic [AXIS_W-1:0] ax_q;

        // Capture this axis on the sample strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ax_q <= '0;
            else if (smp_load)
                ax_q <= smp_axes[g*AXIS_W +: AXIS_W];
        end

        assign axes_q[g*AXIS_W +: AXIS_W] = ax_q;
    end

    // Capture the status byte with the sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (smp_load)
            status_q <= smp_status;
    end

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_load |=> ($stable(axes_q) && $stable(status_q)));
    // R8
    data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_load |=> (axes_q == $past(smp_axes) && status_q == $past(smp_status)));

endmodule

// File: rtl/sensor_read_mux.sv
// Combinational read selection by address: writable registers, axis bytes
// high-first, status, identification constants; zero elsewhere.
module sensor_read_mux
    import sensor_regmap_pkg::*;
#(
    parameter int unsigned              AXIS_W   = 16,
    parameter logic [NUM_ID*BYTE_W-1:0] ID_BYTES = 24'h33_34_48
) (
    input  byte_t                      addr,
    input  logic [NUM_RW*BYTE_W-1:0]   rw_flat,
    input  logic [NUM_AXIS*AXIS_W-1:0] axes_q,
    input  byte_t                      status_q,
    output byte_t                      rd_data
);

    localparam int unsigned BYTES_PER_AXIS = AXIS_W / BYTE_W;

    // Pick the byte at the given address.
    always_comb begin
        int unsigned       k;
        logic [AXIS_W-1:0] sel;
        rd_data = '0;
        k       = 0;
        sel     = '0;
        if (addr < A_DATA_BASE) begin
            rd_data = rw_flat[int'(addr)*BYTE_W +: BYTE_W];
        end else if (addr < A_STATUS) begin
            k       = int'(addr - A_DATA_BASE);
            sel     = axes_q[(k / BYTES_PER_AXIS)*AXIS_W +: AXIS_W];
            rd_data = sel[(BYTES_PER_AXIS - 1 - (k % BYTES_PER_AXIS))*BYTE_W +: BYTE_W];
        end else if (addr == A_STATUS) begin
            rd_data = status_q;
        end else if (addr <= A_LAST) begin
            k       = int'(addr - A_ID_BASE);
            rd_data = ID_BYTES[k*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/sensor_regmap.sv
// Top of the sensor register map: pointer control, writable registers,
// sample storage and a registered read port. Assumes the bus front end
// issues at most one strobe per cycle.
module sensor_regmap
    import sensor_regmap_pkg::*;
#(
    parameter logic [7:0]  CFG_A_RST  = 8'h10,
    parameter logic [7:0]  CFG_B_RST  = 8'h20,
    parameter logic [7:0]  MODE_RST   = 8'h01,
    parameter logic [7:0]  CFG_A_MASK = 8'h1F,
    parameter logic [7:0]  CFG_B_MASK = 8'hE0,
    parameter logic [7:0]  MODE_MASK  = 8'h03,
    parameter logic [7:0]  ID_A       = 8'h48,
    parameter logic [7:0]  ID_B       = 8'h34,
    parameter logic [7:0]  ID_C       = 8'h33,
    parameter int unsigned AXIS_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              wr_valid,
    input  logic [7:0]        wr_byte,
    input  logic              rd_req,
    output logic [7:0]        rd_byte,
    input  logic              smp_load,
    input  logic [AXIS_W-1:0] smp_x,
    input  logic [AXIS_W-1:0] smp_y,
    input  logic [AXIS_W-1:0] smp_z,
    input  logic [7:0]        smp_status,
    output logic [7:0]        cfg_a,
    output logic [7:0]        cfg_b,
    output logic [7:0]        mode,
    output logic              mode_pulse
);

    byte_t                      ptr;
    acc_t                       acc;
    logic [NUM_RW*BYTE_W-1:0]   rw_flat;
    logic [NUM_AXIS*AXIS_W-1:0] axes_q;
    byte_t                      status_q;
    byte_t                      rd_data;

    sensor_ptr_ctrl u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .wr_valid  (wr_valid),
        .wr_byte   (wr_byte),
        .rd_req    (rd_req),
        .ptr       (ptr),
        .acc       (acc)
    );

    sensor_cfg_regs #(
        .RST_VALS ({MODE_RST, CFG_B_RST, CFG_A_RST}),
        .MASKS    ({MODE_MASK, CFG_B_MASK, CFG_A_MASK})
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (acc == ACC_WR),
        .wr_addr    (ptr),
        .wr_data    (wr_byte),
        .rw_flat    (rw_flat),
        .mode_pulse (mode_pulse)
    );

    // Storage order is X, Z, Y, matching the readout order.
    sensor_data_regs #(
        .AXIS_W (AXIS_W)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_load   (smp_load),
        .smp_axes   ({smp_y, smp_z, smp_x}),
        .smp_status (smp_status),
        .axes_q     (axes_q),
        .status_q   (status_q)
    );

    sensor_read_mux #(
        .AXIS_W   (AXIS_W),
        .ID_BYTES ({ID_C, ID_B, ID_A})
    ) u_mux (
        .addr     (ptr),
        .rw_flat  (rw_flat),
        .axes_q   (axes_q),
        .status_q (status_q),
        .rd_data  (rd_data)
    );

    assign cfg_a = rw_flat[0*BYTE_W +: BYTE_W];
    assign cfg_b = rw_flat[1*BYTE_W +: BYTE_W];
    assign mode  = rw_flat[2*BYTE_W +: BYTE_W];

    // Register the selected byte on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_byte <= '0;
        else if (acc == ACC_RD)
            rd_byte <= rd_data;
    end

    // R5
    rd_invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_RD && ptr > A_LAST) |=> rd_byte == 8'h00);
    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_RD) |=> $stable(rd_byte));
    // R7
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_WR && ptr >= A_DATA_BASE) |=> $stable(rw_flat));

endmodule

// File: tb/sensor_regmap_test.sv
module sensor_regmap_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_byte;
    logic        smp_load = 1'b0;
    logic [15:0] smp_x = 16'h0, smp_y = 16'h0, smp_z = 16'h0;
    logic [7:0]  smp_status = 8'h0;
    logic [7:0]  cfg_a, cfg_b, mode;
    logic        mode_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_cfg [3];
    logic [7:0]  m_mask [3];
    logic [15:0] mx, my, mz;
    logic [7:0]  mst;
    int          mptr;

    always #4 clk = ~clk;

    sensor_regmap uut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .wr_valid(wr_valid),
        .wr_byte(wr_byte), .rd_req(rd_req), .rd_byte(rd_byte),
        .smp_load(smp_load), .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .smp_status(smp_status), .cfg_a(cfg_a), .cfg_b(cfg_b), .mode(mode),
        .mode_pulse(mode_pulse)
    );

    function automatic int nxt(input int p);
        if (p == 9) return 3;
        else if (p >= 12) return 0;
        else return p + 1;
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        case (a)
            0, 1, 2: return m_cfg[a];
            3:  return mx[15:8];
            4:  return mx[7:0];
            5:  return mz[15:8];
            6:  return mz[7:0];
            7:  return my[15:8];
            8:  return my[7:0];
            9:  return mst;
            10: return 8'h48;
            11: return 8'h34;
            12: return 8'h33;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Pointer-only transaction (R2).
    task automatic set_ptr(input int a);
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        wr_valid  = 1'b1;
        wr_byte   = a[7:0];
        @(negedge clk);
        wr_valid  = 1'b0;
        mptr      = a;
    endtask

    task automatic wr_data(input logic [7:0] d);
        bit was_mode;
        was_mode = (mptr == 2);
        wr_valid = 1'b1;
        wr_byte  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        if (mptr <= 2) m_cfg[mptr] = d & m_mask[mptr];
        mptr = nxt(mptr);
        chk("R9 mode_pulse after write", 32'(mode_pulse), 32'(was_mode));
        chk("R10 cfg_a", 32'(cfg_a), 32'(m_cfg[0]));
        chk("R10 cfg_b", 32'(cfg_b), 32'(m_cfg[1]));
        chk("R10 mode", 32'(mode), 32'(m_cfg[2]));
        @(negedge clk);
        chk("R9 mode_pulse one cycle", 32'(mode_pulse), 32'd0);
    endtask

    task automatic rd_check(input string req);
        int a;
        a = mptr;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk((a > 12) ? {req, " R5"} : req, 32'(rd_byte), 32'(exp_rd(a)));
        mptr = nxt(mptr);
    endtask

    task automatic load_sample(input logic [15:0] x, input logic [15:0] y,
                               input logic [15:0] z, input logic [7:0] s);
        smp_x = x; smp_y = y; smp_z = z; smp_status = s;
        smp_load = 1'b1;
        @(negedge clk);
        smp_load = 1'b0;
        mx = x; my = y; mz = z; mst = s;
        smp_x = ~x; smp_y = ~y; smp_z = ~z; smp_status = ~s;
    endtask

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h5A;
        m_cfg[0] = 8'h10; m_cfg[1] = 8'h20; m_cfg[2] = 8'h01;
        m_mask[0] = 8'h1F; m_mask[1] = 8'hE0; m_mask[2] = 8'h03;
        mx = 0; my = 0; mz = 0; mst = 0; mptr = 0;

        repeat (3) @(negedge clk);
        chk("R1 cfg_a in reset", 32'(cfg_a), 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cfg_a", 32'(cfg_a), 32'h10);
        chk("R1 cfg_b", 32'(cfg_b), 32'h20);
        chk("R1 mode", 32'(mode), 32'h01);
        chk("R1 mode_pulse", 32'(mode_pulse), 32'd0);
        chk("R1 rd_byte", 32'(rd_byte), 32'd0);

        // Reads with no start: pointer starts at 0 (R1), map contents (R4).
        for (int i = 0; i < 14; i++) rd_check("R1 R4 reset read");

        // New sample visible; unloaded input changes have no effect (R8).
        load_sample(16'h1234, 16'h9ABC, 16'h5678, 8'h03);
        repeat (2) @(negedge clk);
        set_ptr(3);
        for (int i = 0; i < 8; i++) rd_check("R8 sample read");

        // Pointer sweep from every start address (R3, R4, R5).
        for (int a = 0; a <= 20; a++) begin
            set_ptr(a);
            for (int i = 0; i < 15; i++) rd_check("R3 R4 burst");
        end
        set_ptr(255);
        rd_check("R5 top address");
        rd_check("R3 wrap from 255");

        // Write sweep: masks, read-only, pointer advance on ignored writes.
        for (int a = 0; a <= 15; a++) begin
            for (int p = 0; p < 4; p++) begin
                set_ptr(a);
                wr_data(pats[p]);
                rd_check("R7 advance after write");
                set_ptr(a);
                rd_check((a <= 2) ? "R6 masked readback" : "R7 read-only readback");
            end
        end

        // Pointer-only transactions write nothing (R2).
        set_ptr(2);
        set_ptr(0);
        set_ptr(10);
        chk("R2 mode untouched", 32'(mode), 32'(m_cfg[2]));
        chk("R2 cfg_a untouched", 32'(cfg_a), 32'(m_cfg[0]));
        rd_check("R2 reposition");

        // Burst write over the writable registers and into read-only space.
        set_ptr(0);
        wr_data(8'hFF); wr_data(8'hFF); wr_data(8'hFF); wr_data(8'hFF);
        set_ptr(0);
        for (int i = 0; i < 5; i++) rd_check("R6 R7 burst write");

        // Looping axis read with a new sample in between (R3, R8).
        load_sample(16'hBEEF, 16'h0F0F, 16'hC001, 8'h01);
        set_ptr(7);
        for (int i = 0; i < 16; i++) rd_check("R3 R8 loop read");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule